// File: doc/BRIEF.md
# Modulo-31 Direct-Mapped Row Address Cache

This block shortens row-activate address transfers by caching the upper part of each row address, once per bank, on both ends of a link. The controller half takes a bank number and an 18-bit row. It looks up a direct-mapped set chosen by bits [15:11] of the row, then sends one or two 16-bit transfer words. The device half receives those words and rebuilds the full row. Its cache copy stays identical to the controller's because both halves apply the same replacement on every miss.

Each bank has 31 sets. Set index 31 does not exist, so an index value of 31 folds onto set 0. Since two different index values share set 0, each entry holds the whole 7-bit upper portion (bits [17:11]) and not a shorter tag. The 5-bit code field of a transfer word either names a hitting set (0 to 30) or carries the all-ones miss marker. On a miss, a second word follows with the upper portion in its low 7 bits.

Both halves are in the same module and have separate ports. In a system the controller outputs drive the link, and the link delivers the words to the device inputs.

Top module: `rc31_rowcache`

## Requirements
- R1: After reset every set of every bank is invalid, so the first request to any row is encoded as a miss. Immediately after reset `ca_valid` and `row_valid` are 0 and `req_ready` is 1.
- R2: The set is chosen by row bits [15:11]. The value 31 selects set 0, so a row with index 31 and a row with index 0 evict each other.
- R3: A hit sends a single word, one cycle after the request is accepted. The word carries the set number (0 to 30) in bits [15:11] and row bits [10:0] in bits [10:0].
- R4: A miss sends a first word of {5'b11111, row[10:0]} one cycle after acceptance. The next cycle it sends a second word of {9'b0, row[17:11]}. `req_ready` is 0 during the cycle of the first word.
- R5: A miss writes row[17:11] into the indexed set of the requesting bank, in both the controller cache and the device cache. A later request to the same row in the same bank then hits.
- R6: A hit requires a valid entry whose stored 7 bits equal row[17:11] exactly. A row that shares bits [15:11] but differs in bits [17:16] misses and replaces the entry.
- R7: The device output presents the requested row with `row_valid` one cycle after the word that completes it. On a hit the row is {stored 7 bits, word[10:0]}. On a miss it is {second word[6:0], first word[10:0]}.
- R8: Banks are independent. Each has its own 31 sets, and the bank number travels with each word and with each rebuilt row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Controller activate request present |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 18 | Row address of the request |
| req_ready | output | 1 | Request is accepted this cycle when high |
| ca_valid | output | 1 | Transfer word valid on the link |
| ca_bank | output | 2 | Bank the transfer word belongs to |
| ca_word | output | 16 | Transfer word |
| dev_valid | input | 1 | Transfer word arriving at the device |
| dev_bank | input | 2 | Bank of the arriving word |
| dev_word | input | 16 | Arriving transfer word |
| row_valid | output | 1 | Rebuilt row valid |
| row_bank | output | 2 | Bank of the rebuilt row |
| row_addr | output | 18 | Rebuilt row address |

## Verification
A hit word appears on the link one cycle after acceptance, and the rebuilt row one cycle later. A miss puts its marker word out one cycle after acceptance and its upper-portion word the cycle after that. The row then follows one cycle behind the second word. The bench loops the link outputs into the device inputs and queues every expected word and row in acceptance order as it drives each request. Monitors compare the outputs at the falling edge of each cycle in which a valid flag is high, so each result is taken in the exact cycle it is due. A word or row that arrives too early, too late or unexpected shows up as a miscompare or a leftover queue entry.

// File: rtl/rc31_pkg.sv
package rc31_pkg;

  typedef enum logic {
    ENC_IDLE = 1'b0,
    ENC_TAIL = 1'b1
  } enc_state_e;

  typedef enum logic {
    DEC_HEAD = 1'b0,
    DEC_TAIL = 1'b1
  } dec_state_e;

  // Fold a raw index onto the implemented sets (index == sets wraps to 0).
  function automatic int fold_set(input int raw, input int sets);
    return (raw >= sets) ? raw - sets : raw;
  endfunction

endpackage

// File: rtl/rc31_store.sv
module rc31_store #(
  parameter int BANKS  = 4,
  parameter int SETS   = 31,
  parameter int UP_W   = 7,
  parameter int BANK_W = 2,
  parameter int SET_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic [UP_W-1:0]   rd_tag,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [UP_W-1:0]   wr_tag
);

  logic [BANKS-1:0] bank_vld;
  logic [UP_W-1:0]  bank_tag [BANKS];
  logic             rd_in_range;

  assign rd_in_range = (32'(rd_set) < SETS);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [SETS-1:0] vld_q;
    logic [UP_W-1:0] tag_q [SETS];
    logic            we;

    assign we = wr_en && (wr_bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else if (we) begin
        vld_q[wr_set] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (we) begin
        tag_q[wr_set] <= wr_tag;
      end
    end

    assign bank_vld[b] = vld_q[rd_set];
    assign bank_tag[b] = tag_q[rd_set];
  end

  assign rd_valid = rd_in_range && bank_vld[rd_bank];
  assign rd_tag   = bank_tag[rd_bank];

endmodule

// File: rtl/rc31_enc.sv
module rc31_enc #(
  parameter int ROW_W  = 18,
  parameter int WORD_W = 16,
  parameter int LOW_W  = 11,
  parameter int SETS   = 31,
  parameter int BANK_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [BANK_W-1:0]      req_bank,
  input  logic [ROW_W-1:0]       req_row,
  output logic                   req_ready,
  output logic                   ca_valid,
  output logic [BANK_W-1:0]      ca_bank,
  output logic [WORD_W-1:0]      ca_word,
  output logic [BANK_W-1:0]      lk_bank,
  output logic [WORD_W-LOW_W-1:0] lk_set,
  input  logic                   lk_valid,
  input  logic [ROW_W-LOW_W-1:0] lk_tag,
  output logic                   upd_en,
  output logic [BANK_W-1:0]      upd_bank,
  output logic [WORD_W-LOW_W-1:0] upd_set,
  output logic [ROW_W-LOW_W-1:0] upd_tag
);
  import rc31_pkg::*;

  localparam int UP_W   = ROW_W - LOW_W;
  localparam int CODE_W = WORD_W - LOW_W;
  localparam logic [CODE_W-1:0] MISS = '1;

  enc_state_e        state_q, state_d;
  logic              valid_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [UP_W-1:0]   tail_q, tail_d;
  logic              load_en;

  logic [UP_W-1:0]   up;
  logic [LOW_W-1:0]  low;
  logic [CODE_W-1:0] set_idx;
  logic              hit;
  logic              accept;

  assign up      = req_row[ROW_W-1:LOW_W];
  assign low     = req_row[LOW_W-1:0];
  assign set_idx = CODE_W'(fold_set(int'(up[CODE_W-1:0]), SETS));

  assign lk_bank = req_bank;
  assign lk_set  = set_idx;
  assign hit     = lk_valid && (lk_tag == up);

  assign req_ready = (state_q == ENC_IDLE);
  assign accept    = req_valid && req_ready;

  assign upd_en   = accept && !hit;
  assign upd_bank = req_bank;
  assign upd_set  = set_idx;
  assign upd_tag  = up;

  always_comb begin
    state_d = state_q;
    valid_d = 1'b0;
    word_d  = word_q;
    bank_d  = bank_q;
    tail_d  = tail_q;
    load_en = 1'b0;
    case (state_q)
      ENC_IDLE: begin
        if (accept) begin
          load_en = 1'b1;
          valid_d = 1'b1;
          bank_d  = req_bank;
          if (hit) begin
            word_d = {set_idx, low};
          end else begin
            word_d  = {MISS, low};
            tail_d  = up;
            state_d = ENC_TAIL;
          end
        end
      end
      ENC_TAIL: begin
        load_en = 1'b1;
        valid_d = 1'b1;
        word_d  = WORD_W'(tail_q);
        state_d = ENC_IDLE;
      end
      default: state_d = ENC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENC_IDLE;
      ca_valid <= 1'b0;
    end else begin
      state_q  <= state_d;
      ca_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      word_q <= word_d;
      bank_q <= bank_d;
      tail_q <= tail_d;
    end
  end

  assign ca_word = word_q;
  assign ca_bank = bank_q;

endmodule

// File: rtl/rc31_dec.sv
module rc31_dec #(
  parameter int ROW_W  = 18,
  parameter int WORD_W = 16,
  parameter int LOW_W  = 11,
  parameter int SETS   = 31,
  parameter int BANK_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dev_valid,
  input  logic [BANK_W-1:0]       dev_bank,
  input  logic [WORD_W-1:0]       dev_word,
  output logic                    row_valid,
  output logic [BANK_W-1:0]       row_bank,
  output logic [ROW_W-1:0]        row_addr,
  output logic [BANK_W-1:0]       lk_bank,
  output logic [WORD_W-LOW_W-1:0] lk_set,
  input  logic                    lk_valid,
  input  logic [ROW_W-LOW_W-1:0]  lk_tag,
  output logic                    upd_en,
  output logic [BANK_W-1:0]       upd_bank,
  output logic [WORD_W-LOW_W-1:0] upd_set,
  output logic [ROW_W-LOW_W-1:0]  upd_tag
);
  import rc31_pkg::*;

  localparam int UP_W   = ROW_W - LOW_W;
  localparam int CODE_W = WORD_W - LOW_W;
  localparam logic [CODE_W-1:0] MISS = '1;

  dec_state_e        state_q, state_d;
  logic              valid_d;
  logic [ROW_W-1:0]  row_d;
  logic [BANK_W-1:0] rbank_d;
  logic              out_en;
  logic [LOW_W-1:0]  low_q, low_d;
  logic [BANK_W-1:0] hold_q, hold_d;
  logic              hold_en;

  logic [CODE_W-1:0] code;
  logic [LOW_W-1:0]  low;
  logic [UP_W-1:0]   tail_up;

  assign code    = dev_word[WORD_W-1:LOW_W];
  assign low     = dev_word[LOW_W-1:0];
  assign tail_up = dev_word[UP_W-1:0];

  assign lk_bank = dev_bank;
  assign lk_set  = code;

  assign upd_bank = hold_q;
  assign upd_set  = CODE_W'(fold_set(int'(tail_up[CODE_W-1:0]), SETS));
  assign upd_tag  = tail_up;

  always_comb begin
    state_d = state_q;
    valid_d = 1'b0;
    row_d   = row_addr;
    rbank_d = row_bank;
    out_en  = 1'b0;
    low_d   = low_q;
    hold_d  = hold_q;
    hold_en = 1'b0;
    upd_en  = 1'b0;
    case (state_q)
      DEC_HEAD: begin
        if (dev_valid) begin
          if (code == MISS) begin
            hold_en = 1'b1;
            low_d   = low;
            hold_d  = dev_bank;
            state_d = DEC_TAIL;
          end else begin
            out_en  = 1'b1;
            valid_d = 1'b1;
            rbank_d = dev_bank;
            row_d   = {lk_tag, low};
          end
        end
      end
      DEC_TAIL: begin
        if (dev_valid) begin
          out_en  = 1'b1;
          valid_d = 1'b1;
          rbank_d = hold_q;
          row_d   = {tail_up, low_q};
          upd_en  = 1'b1;
          state_d = DEC_HEAD;
        end
      end
      default: state_d = DEC_HEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= DEC_HEAD;
      row_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      row_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (out_en) begin
      row_addr <= row_d;
      row_bank <= rbank_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) begin
      low_q  <= low_d;
      hold_q <= hold_d;
    end
  end

  // lk_valid is not needed: the device trusts the controller's hit code.
  logic unused_ok;
  assign unused_ok = lk_valid;

endmodule

// File: rtl/rc31_rowcache.sv
module rc31_rowcache #(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 18,
  parameter int WORD_W = 16,
  parameter int LOW_W  = 11,
  parameter int SETS   = 31,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  output logic              req_ready,
  output logic              ca_valid,
  output logic [BANK_W-1:0] ca_bank,
  output logic [WORD_W-1:0] ca_word,
  input  logic              dev_valid,
  input  logic [BANK_W-1:0] dev_bank,
  input  logic [WORD_W-1:0] dev_word,
  output logic              row_valid,
  output logic [BANK_W-1:0] row_bank,
  output logic [ROW_W-1:0]  row_addr
);

  localparam int UP_W   = ROW_W - LOW_W;
  localparam int CODE_W = WORD_W - LOW_W;

  // Controller side cache wiring
  logic [BANK_W-1:0] c_lk_bank, c_upd_bank;
  logic [CODE_W-1:0] c_lk_set, c_upd_set;
  logic              c_lk_valid, c_upd_en;
  logic [UP_W-1:0]   c_lk_tag, c_upd_tag;

  // Device side cache wiring
  logic [BANK_W-1:0] d_lk_bank, d_upd_bank;
  logic [CODE_W-1:0] d_lk_set, d_upd_set;
  logic              d_lk_valid, d_upd_en;
  logic [UP_W-1:0]   d_lk_tag, d_upd_tag;

  rc31_enc #(
    .ROW_W(ROW_W), .WORD_W(WORD_W), .LOW_W(LOW_W), .SETS(SETS), .BANK_W(BANK_W)
  ) u_enc (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
    .req_ready(req_ready),
    .ca_valid(ca_valid), .ca_bank(ca_bank), .ca_word(ca_word),
    .lk_bank(c_lk_bank), .lk_set(c_lk_set), .lk_valid(c_lk_valid), .lk_tag(c_lk_tag),
    .upd_en(c_upd_en), .upd_bank(c_upd_bank), .upd_set(c_upd_set), .upd_tag(c_upd_tag)
  );

  rc31_store #(
    .BANKS(BANKS), .SETS(SETS), .UP_W(UP_W), .BANK_W(BANK_W), .SET_W(CODE_W)
  ) u_ctrl_store (
    .clk(clk), .rst_n(rst_n),
    .rd_bank(c_lk_bank), .rd_set(c_lk_set), .rd_valid(c_lk_valid), .rd_tag(c_lk_tag),
    .wr_en(c_upd_en), .wr_bank(c_upd_bank), .wr_set(c_upd_set), .wr_tag(c_upd_tag)
  );

  rc31_dec #(
    .ROW_W(ROW_W), .WORD_W(WORD_W), .LOW_W(LOW_W), .SETS(SETS), .BANK_W(BANK_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .dev_valid(dev_valid), .dev_bank(dev_bank), .dev_word(dev_word),
    .row_valid(row_valid), .row_bank(row_bank), .row_addr(row_addr),
    .lk_bank(d_lk_bank), .lk_set(d_lk_set), .lk_valid(d_lk_valid), .lk_tag(d_lk_tag),
    .upd_en(d_upd_en), .upd_bank(d_upd_bank), .upd_set(d_upd_set), .upd_tag(d_upd_tag)
  );

  rc31_store #(
    .BANKS(BANKS), .SETS(SETS), .UP_W(UP_W), .BANK_W(BANK_W), .SET_W(CODE_W)
  ) u_dev_store (
    .clk(clk), .rst_n(rst_n),
    .rd_bank(d_lk_bank), .rd_set(d_lk_set), .rd_valid(d_lk_valid), .rd_tag(d_lk_tag),
    .wr_en(d_upd_en), .wr_bank(d_upd_bank), .wr_set(d_upd_set), .wr_tag(d_upd_tag)
  );

endmodule

// File: rtl/rc31_checker.sv
module rc31_checker #(
  parameter int ROW_W  = 18,
  parameter int WORD_W = 16,
  parameter int LOW_W  = 11,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic              req_ready,
  input logic              ca_valid,
  input logic [BANK_W-1:0] ca_bank,
  input logic [WORD_W-1:0] ca_word,
  input logic              dev_valid,
  input logic [BANK_W-1:0] dev_bank,
  input logic [WORD_W-1:0] dev_word,
  input logic              row_valid,
  input logic [BANK_W-1:0] row_bank,
  input logic [ROW_W-1:0]  row_addr
);
  localparam int UP_W   = ROW_W - LOW_W;
  localparam int CODE_W = WORD_W - LOW_W;
  localparam logic [CODE_W-1:0] MISS = '1;

  // An accepted request always puts a word on the link next cycle.
  assert_accept_emits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ca_valid);

  // While a second word is owed, the current word is the miss marker.
  assert_marker_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (ca_valid && ca_word[WORD_W-1:LOW_W] == MISS));

  // The owed word follows at once, holds only the upper portion, and frees the port.
  assert_tail_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (ca_valid && req_ready && ca_word[WORD_W-1:UP_W] == '0));

  // A rebuilt row always follows a received word by one cycle.
  assert_row_after_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> $past(dev_valid));

  // A hit row carries the low bits of the word that produced it.
  assert_hit_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && $past(dev_word[WORD_W-1:LOW_W]) != MISS &&
     $past(dev_word[WORD_W-1:UP_W]) != '0)
    |-> row_addr[LOW_W-1:0] == $past(dev_word[LOW_W-1:0]));

  // The link bank stays put across the two words of a miss.
  assert_bank_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(ca_bank));

  logic unused_ok;
  assign unused_ok = ^{req_bank, req_row, dev_bank, row_bank};

endmodule

bind rc31_rowcache rc31_checker #(
  .ROW_W(ROW_W), .WORD_W(WORD_W), .LOW_W(LOW_W), .BANK_W(BANK_W)
) i_rc31_checker (.*);

// File: tb/test_rc31_rowcache.sv
module test_rc31_rowcache;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_bank;
  logic [17:0] req_row;
  logic        req_ready;
  logic        ca_valid;
  logic [1:0]  ca_bank;
  logic [15:0] ca_word;
  logic        dev_valid;
  logic [1:0]  dev_bank;
  logic [15:0] dev_word;
  logic        row_valid;
  logic [1:0]  row_bank;
  logic [17:0] row_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // Link loop: controller words go straight to the device side.
  assign dev_valid = ca_valid;
  assign dev_bank  = ca_bank;
  assign dev_word  = ca_word;

  rc31_rowcache i_rc31_rowcache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
    .req_ready(req_ready),
    .ca_valid(ca_valid), .ca_bank(ca_bank), .ca_word(ca_word),
    .dev_valid(dev_valid), .dev_bank(dev_bank), .dev_word(dev_word),
    .row_valid(row_valid), .row_bank(row_bank), .row_addr(row_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // Reference cache model
  bit         m_vld [4][31];
  logic [6:0] m_tag [4][31];

  logic [17:0] exp_word_q [$];   // {bank, word}
  string       exp_word_r [$];
  logic [19:0] exp_row_q  [$];   // {bank, row}

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  task automatic send(input int bank, input logic [17:0] row, input string req);
    logic [6:0] up;
    int         idx;
    int         set;
    bit         hit;
    up  = row[17:11];
    idx = int'(up[4:0]);
    set = (idx == 31) ? 0 : idx;
    hit = m_vld[bank][set] && (m_tag[bank][set] == up);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_bank  = 2'(bank);
    req_row   = row;
    if (hit) begin
      exp_word_q.push_back({2'(bank), 5'(set), row[10:0]});
      exp_word_r.push_back({req, " R3"});
    end else begin
      exp_word_q.push_back({2'(bank), 5'h1f, row[10:0]});
      exp_word_r.push_back({req, " R4"});
      exp_word_q.push_back({2'(bank), 9'h000, up});
      exp_word_r.push_back({req, " R4"});
      m_vld[bank][set] = 1'b1;
      m_tag[bank][set] = up;
    end
    exp_row_q.push_back({2'(bank), row});
    @(negedge clk);
    req_valid = 1'b0;
    if (!hit) check(req_ready == 1'b0, "R4", "ready during marker word",
                    32'(req_ready), 32'h0);
  endtask

  // Link monitor
  always @(negedge clk) begin
    if (rst_n && ca_valid && !done) begin
      if (exp_word_q.size() == 0) begin
        check(1'b0, "R3 R4", "unexpected link word", 32'({ca_bank, ca_word}), 32'h0);
      end else begin
        logic [17:0] e;
        string       r;
        e = exp_word_q.pop_front();
        r = exp_word_r.pop_front();
        check({ca_bank, ca_word} == e, r, "link word", 32'({ca_bank, ca_word}), 32'(e));
      end
    end
  end

  // Device row monitor
  always @(negedge clk) begin
    if (rst_n && row_valid && !done) begin
      if (exp_row_q.size() == 0) begin
        check(1'b0, "R7", "unexpected row", 32'({row_bank, row_addr}), 32'h0);
      end else begin
        logic [19:0] e;
        e = exp_row_q.pop_front();
        check({row_bank, row_addr} == e, "R7 R8", "rebuilt row",
              32'({row_bank, row_addr}), 32'(e));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 31; s++) begin
        m_vld[b][s] = 1'b0;
        m_tag[b][s] = '0;
      end
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_bank  = '0;
    req_row   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(ca_valid == 1'b0, "R1", "ca_valid after reset", 32'(ca_valid), 32'h0);
    check(row_valid == 1'b0, "R1", "row_valid after reset", 32'(row_valid), 32'h0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);

    // R1/R5: first access misses, repeat hits
    send(0, {7'b0000011, 11'h155}, "R1");
    send(0, {7'b0000011, 11'h2aa}, "R5");
    send(0, {7'b0000011, 11'h001}, "R5");

    // R6: same index, different upper bits
    send(0, {7'b0100011, 11'h0f0}, "R6");
    send(0, {7'b0000011, 11'h0f1}, "R6");
    send(0, {7'b0000011, 11'h0f2}, "R6");

    // R2: index 31 folds onto set 0
    send(1, {7'b0000000, 11'h010}, "R2");
    send(1, {7'b0000000, 11'h011}, "R2");
    send(1, {7'b0011111, 11'h012}, "R2");
    send(1, {7'b0011111, 11'h013}, "R2");
    send(1, {7'b0000000, 11'h014}, "R2");
    send(1, {7'b1111110, 11'h7ff}, "R3");
    send(1, {7'b1111110, 11'h000}, "R3");

    // R8: bank independence
    send(2, {7'b0000011, 11'h155}, "R8");
    send(0, {7'b0000011, 11'h156}, "R8");
    send(3, {7'b0000011, 11'h157}, "R8");
    send(2, {7'b0000011, 11'h158}, "R8");

    // Mixed stream with idle gaps
    for (int i = 0; i < 300; i++) begin
      logic [6:0] up;
      int         k;
      k = int'($urandom_range(0, 4));
      up = {1'b0, 1'($urandom_range(0, 1)), (k == 4) ? 5'd31 : 5'(k)};
      send(int'($urandom_range(0, 3)), {up, 11'($urandom)}, "R5");
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    repeat (8) @(negedge clk);
    check(exp_word_q.size() == 0, "R3 R4", "words left outstanding",
          32'(exp_word_q.size()), 32'h0);
    check(exp_row_q.size() == 0, "R7", "rows left outstanding",
          32'(exp_row_q.size()), 32'h0);
    done = 1;
    summary();
    $finish;
  end

endmodule